// File: doc/BRIEF.md
# Programmable Interval Timer

The block is a software-programmed interval timer reached through a small register bus. An up-counting count register advances by a fixed increment on each timer tick while the timer is running. When the count carries out past all-ones it reloads from a next-interval register and sets a done flag. If interrupts are enabled, done drives a level interrupt request. Software can load the count from the next-interval register, step it by one while stopped, and clear status bits by writing ones to them.

Two tick sources exist. The general tick `tick_i` adds `TICK_INC` per strobe. The standard-interval strobe `std_tick_i` adds `STD_INC` per strobe and counts only when the standard-interval flag is set. A two-state machine tracks the counter. `ST_STOPPED` moves to `ST_RUNNING` on any control write with run=1, and `ST_RUNNING` moves back to `ST_STOPPED` on any control write with run=0. A control write and a tick in the same cycle give the write priority, and that tick is dropped.

Register map, 32-bit words at word offsets: 0 is control/status, 1 is next-interval (read/write), 2 is count (read-only), and 3 reads as zero. Control/status bits:

| Bit | Name | Access |
|-----|------|--------|
| 0 | run | read/write |
| 1 | std (standard-interval select) | read/write |
| 2 | load (transfer command) | command, reads 0 |
| 3 | step (single-step) | read/write |
| 6 | ie (interrupt enable) | read/write |
| 7 | done | write-one-to-clear |
| 15 | err | write-one-to-clear |

Top module: `interval_timer`

## Requirements
- R1: After reset, all three registers read 0 and `irq_o` is 0.
- R2: Offset 1 reads back the value last written to it. A write to offset 2 leaves the count unchanged.
- R3: In state `ST_RUNNING` with std=0, each `tick_i` adds `TICK_INC` to the count, and `std_tick_i` has no effect. With std=1, each `std_tick_i` adds `STD_INC`, and `tick_i` has no effect.
- R4: A control write with bit 0 = 0 enters `ST_STOPPED`. The count then holds its value and ignores ticks, and the std bit reads 0 whatever value was written to it.
- R5: A control write with bit 2 = 1 copies the next-interval register into the count. If bit 0 is also 1, counting continues from the loaded value.
- R6: A control write with bit 0 = 1 and bit 2 = 0 on a running timer leaves the count unchanged, and the timer keeps counting.
- R7: A control write with bit 0 = 0 and bit 3 = 1 adds exactly 1 to the count. If that carries past all-ones, the count is reloaded from next-interval instead, and done is not set. Bit 3 written together with bit 0 = 1 does not step the count.
- R8: When a tick carries the count past all-ones in `ST_RUNNING`, the count is reloaded from next-interval in that same cycle and done (bit 7) becomes 1.
- R9: A carry while done is already 1 sets err (bit 15).
- R10: A control write clears done or err only where the written value has a 1 in that bit. Writing a 0 to those bits leaves them unchanged.
- R11: `irq_o` is 1 exactly when done and ie (bit 6) are both 1. It stays high until one of the two is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write qualifier for the access |
| bus_addr_i | input | ADDR_W | Word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| tick_i | input | 1 | General timer tick strobe |
| std_tick_i | input | 1 | Standard-interval tick strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the tick strobes are single-cycle pulses. They also assume that no tick is expected to count in a cycle that carries a control write, because the write wins that cycle by design. The stimulus issues every bus write as a one-cycle pulse on a falling edge and always separates ticks from writes by at least one idle cycle. The carry and reload cases are reached by loading next-interval values close to all-ones rather than by waiting out a full 32-bit count.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int CSR_RUN  = 0;
    localparam int CSR_STD  = 1;
    localparam int CSR_LOAD = 2;
    localparam int CSR_STEP = 3;
    localparam int CSR_IE   = 6;
    localparam int CSR_DONE = 7;
    localparam int CSR_ERR  = 15;

    localparam int OFS_CSR   = 0;
    localparam int OFS_NEXT  = 1;
    localparam int OFS_COUNT = 2;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic run;
        logic std;
        logic load;
        logic step;
        logic ie;
        logic done;
        logic err;
    } csr_bits_t;
endpackage

// File: rtl/timer_regmap.sv
module timer_regmap
    import timer_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] csr_rd_i,
    input  logic [DATA_W-1:0] count_i,
    output logic              csr_wr_o,
    output logic [DATA_W-1:0] next_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_CSR   = ADDR_W'(OFS_CSR);
    localparam logic [ADDR_W-1:0] A_NEXT  = ADDR_W'(OFS_NEXT);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

    logic [DATA_W-1:0] next_q;
    logic              next_wr;

    assign csr_wr_o = sel_i && wr_i && (addr_i == A_CSR);
    assign next_wr  = sel_i && wr_i && (addr_i == A_NEXT);

    always_ff @(posedge clk) begin
        if (!rst_n)       next_q <= '0;
        else if (next_wr) next_q <= wdata_i;
    end

    assign next_o = next_q;

    always_comb begin
        unique case (addr_i)
            A_CSR:   rdata_o = csr_rd_i;
            A_NEXT:  rdata_o = next_q;
            A_COUNT: rdata_o = count_i;
            default: rdata_o = '0;
        endcase
    end

    // R2: next-interval register takes the written word
    p_next_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        next_wr |=> (next_o == $past(wdata_i)));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_i,
    input  csr_bits_t         wbits_i,
    input  logic              tick_i,
    input  logic              std_tick_i,
    input  logic              wrap_i,
    output logic              load_o,
    output logic              step_o,
    output logic              adv_o,
    output logic              std_sel_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] csr_rd_o
);
    tmr_state_e state_q, state_d;
    logic std_q, step_q, ie_q, done_q, err_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (csr_wr_i && wbits_i.run)  state_d = ST_RUNNING;
            ST_RUNNING: if (csr_wr_i && !wbits_i.run) state_d = ST_STOPPED;
            default:    state_d = ST_STOPPED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        adv_o  = 1'b0;
        step_o = 1'b0;
        load_o = csr_wr_i && wbits_i.load;
        unique case (state_q)
            ST_STOPPED: step_o = csr_wr_i && !wbits_i.run && wbits_i.step;
            ST_RUNNING: begin
                adv_o  = !csr_wr_i && (std_q ? std_tick_i : tick_i);
                step_o = csr_wr_i && !wbits_i.run && wbits_i.step;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q  <= 1'b0;
            step_q <= 1'b0;
            ie_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (csr_wr_i) begin
            std_q  <= wbits_i.run && wbits_i.std;
            step_q <= wbits_i.step;
            ie_q   <= wbits_i.ie;
            done_q <= done_q && !wbits_i.done;
            err_q  <= err_q && !wbits_i.err;
        end else if (wrap_i) begin
            done_q <= 1'b1;
            if (done_q) err_q <= 1'b1;
        end
    end

    assign std_sel_o = std_q;
    assign irq_o     = done_q && ie_q;

    always_comb begin
        csr_rd_o           = '0;
        csr_rd_o[CSR_RUN]  = (state_q == ST_RUNNING);
        csr_rd_o[CSR_STD]  = std_q;
        csr_rd_o[CSR_STEP] = step_q;
        csr_rd_o[CSR_IE]   = ie_q;
        csr_rd_o[CSR_DONE] = done_q;
        csr_rd_o[CSR_ERR]  = err_q;
    end

    // R8: a carry while running sets done
    p_wrap_sets_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> done_q);
    // R9: a carry on top of a pending done sets err
    p_double_wrap_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && done_q) |=> err_q);
    // R10: zero written to done leaves it set
    p_w1c_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_i && !wbits_i.done && done_q) |=> done_q);
    // R4: counting never advances while stopped
    p_no_adv_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |-> !adv_o);
endmodule

// File: rtl/timer_count.sv
module timer_count #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] TICK_INC = 1,
    parameter logic [DATA_W-1:0] STD_INC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              adv_i,
    input  logic              std_sel_i,
    input  logic [DATA_W-1:0] next_i,
    output logic              wrap_o,
    output logic [DATA_W-1:0] count_o
);
    localparam logic [DATA_W:0] ONE = (DATA_W+1)'(1);

    logic [DATA_W-1:0] count_q, base, inc;
    logic [DATA_W:0]   step_sum, adv_sum;

    assign base     = load_i ? next_i : count_q;
    assign inc      = std_sel_i ? STD_INC : TICK_INC;
    assign step_sum = {1'b0, base} + ONE;
    assign adv_sum  = {1'b0, count_q} + {1'b0, inc};
    assign wrap_o   = adv_i && adv_sum[DATA_W];

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else if (step_i)
            count_q <= step_sum[DATA_W] ? next_i : step_sum[DATA_W-1:0];
        else if (load_i)
            count_q <= next_i;
        else if (adv_i)
            count_q <= adv_sum[DATA_W] ? next_i : adv_sum[DATA_W-1:0];
    end

    assign count_o = count_q;

    // R4: with no command and no advance the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i && !adv_i) |=> $stable(count_o));
    // R5: a transfer without a step lands the next-interval value
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !step_i) |=> (count_o == $past(next_i)));
    // R7: a step that does not carry adds exactly one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && (count_o != '1)) |=> (count_o == $past(count_o) + 1'b1));
    // R8: a carrying advance reloads
    p_wrap_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !step_i && !load_i) |=> (count_o == $past(next_i)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] TICK_INC = 1,
    parameter logic [DATA_W-1:0] STD_INC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_i,
    input  logic              std_tick_i,
    output logic              irq_o
);
    logic              csr_wr, load, step, adv, std_sel, wrap;
    logic [DATA_W-1:0] next_val, count_val, csr_rd;
    csr_bits_t         wbits;

    always_comb begin
        wbits.run  = bus_wdata_i[CSR_RUN];
        wbits.std  = bus_wdata_i[CSR_STD];
        wbits.load = bus_wdata_i[CSR_LOAD];
        wbits.step = bus_wdata_i[CSR_STEP];
        wbits.ie   = bus_wdata_i[CSR_IE];
        wbits.done = bus_wdata_i[CSR_DONE];
        wbits.err  = bus_wdata_i[CSR_ERR];
    end

    timer_regmap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regmap (
        .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .csr_rd_i(csr_rd),
        .count_i(count_val), .csr_wr_o(csr_wr), .next_o(next_val),
        .rdata_o(bus_rdata_o)
    );

    timer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr_i(csr_wr), .wbits_i(wbits),
        .tick_i(tick_i), .std_tick_i(std_tick_i), .wrap_i(wrap),
        .load_o(load), .step_o(step), .adv_o(adv), .std_sel_o(std_sel),
        .irq_o(irq_o), .csr_rd_o(csr_rd)
    );

    timer_count #(.DATA_W(DATA_W), .TICK_INC(TICK_INC), .STD_INC(STD_INC)) u_count (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step), .adv_i(adv),
        .std_sel_i(std_sel), .next_i(next_val), .wrap_o(wrap), .count_o(count_val)
    );
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
    localparam int DW = 32;
    localparam logic [DW-1:0] T_INC = 1;
    localparam logic [DW-1:0] S_INC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          tick = 1'b0, stick = 1'b0;
    logic          irq;
    int            n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    interval_timer #(.TICK_INC(T_INC), .STD_INC(S_INC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tick_i(tick), .std_tick_i(stick), .irq_o(irq)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0; wdata = '0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic pulse_tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1; @(negedge clk); tick = 0;
        end
    endtask

    task automatic pulse_std(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); stick = 1; @(negedge clk); stick = 0;
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd_reg(0, v); check("R1 csr", v, 0);
        rd_reg(1, v); check("R1 next", v, 0);
        rd_reg(2, v); check("R1 count", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] v;
        wr_reg(1, 32'hA5A5_0001); rd_reg(1, v); check("R2 next readback", v, 32'hA5A5_0001);
        wr_reg(2, 32'h0000_1234); rd_reg(2, v); check("R2 count read-only", v, 0);
        wr_reg(0, 32'h4); rd_reg(2, v); check("R5 load stopped", v, 32'hA5A5_0001);
    endtask

    task automatic t_run();
        logic [DW-1:0] v;
        wr_reg(1, 100); wr_reg(0, 32'h5);
        rd_reg(2, v); check("R5 load and run", v, 100);
        pulse_tick(3); rd_reg(2, v); check("R3 tick count", v, 100 + 3*T_INC);
        pulse_std(2); rd_reg(2, v); check("R3 std ignored", v, 100 + 3*T_INC);
        wr_reg(0, 32'h1); rd_reg(2, v); check("R6 rewrite run", v, 100 + 3*T_INC);
        pulse_tick(1); rd_reg(2, v); check("R6 still running", v, 100 + 4*T_INC);
        wr_reg(0, 32'h0); pulse_tick(2); rd_reg(2, v); check("R4 stopped hold", v, 100 + 4*T_INC);
        rd_reg(0, v); check("R4 run clear", v, 0);
    endtask

    task automatic t_std();
        logic [DW-1:0] v;
        logic [DW-1:0] base;
        base = 100 + 4*T_INC;
        wr_reg(0, 32'h3); rd_reg(0, v); check("R3 std mode set", v, 32'h3);
        pulse_std(1); rd_reg(2, v); check("R3 std inc", v, base + S_INC);
        pulse_tick(2); rd_reg(2, v); check("R3 tick ignored in std", v, base + S_INC);
        wr_reg(0, 32'h2); rd_reg(0, v); check("R4 std cleared", v, 0);
    endtask

    task automatic t_step();
        logic [DW-1:0] v;
        logic [DW-1:0] base;
        base = 100 + 4*T_INC + S_INC;
        wr_reg(0, 32'h8); rd_reg(2, v); check("R7 step +1", v, base + 1);
        wr_reg(1, 32'hFFFF_FFFF); wr_reg(0, 32'h4); wr_reg(1, 7);
        wr_reg(0, 32'h8); rd_reg(2, v); check("R7 step wrap reload", v, 7);
        rd_reg(0, v); check("R7 no done", v & 32'h80, 0);
        wr_reg(0, 32'h9); rd_reg(2, v); check("R7 no step while run", v, 7);
        wr_reg(0, 32'h0);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] v;
        wr_reg(1, 32'hFFFF_FFFE); wr_reg(0, 32'h45);
        pulse_tick(1); rd_reg(2, v); check("R8 pre-wrap", v, 32'hFFFF_FFFF);
        check("R11 irq low before", {31'b0, irq}, 0);
        pulse_tick(1); rd_reg(2, v); check("R8 reload", v, 32'hFFFF_FFFE);
        rd_reg(0, v); check("R8 done set", v, 32'hC1);
        check("R11 irq high", {31'b0, irq}, 1);
        pulse_tick(2); rd_reg(0, v); check("R9 err set", v, 32'h80C1);
        wr_reg(0, 32'h41); rd_reg(0, v); check("R10 zeros keep", v, 32'h80C1);
        wr_reg(0, 32'hC1); rd_reg(0, v); check("R10 clear done", v, 32'h8041);
        check("R11 irq dropped", {31'b0, irq}, 0);
        wr_reg(0, 32'h8041); rd_reg(0, v); check("R10 clear err", v, 32'h41);
        pulse_tick(2); check("R11 irq again", {31'b0, irq}, 1);
        wr_reg(0, 32'h1); check("R11 ie off", {31'b0, irq}, 0);
        rd_reg(0, v); check("R11 done kept", v, 32'h81);
        wr_reg(0, 32'h41); check("R11 ie on", {31'b0, irq}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_run();
        t_std();
        t_step();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule